// File: doc/BRIEF.md
# Speculative Register Tracker with Future File

This block keeps two copies of every architectural register. The future file is the working copy. It holds the newest speculative value of each register, or, while a result is still being computed, the tag of the instruction that will produce it. The architectural file holds only retired values. Consumers read operands from the future file. Each read port returns a valid flag, the value, and the stored producer tag. When the flag is low, the consumer waits for a writeback carrying that tag.

Dispatch names a destination register, and the block hands back a fresh producer tag in the same cycle. The named future entry loses its valid flag and records that tag. A finishing result is accepted only if its tag matches the entry's recorded producer and the entry is still waiting. Superseded writers therefore cannot disturb newer state. Retirement writes into the architectural file. A one-cycle recovery pulse copies the whole architectural file into the future file and marks every entry valid.

The dispatch, writeback and retire channels are valid-qualified beats, and each accepts at most one per cycle. None of them has a ready signal. The block never applies back-pressure, so every asserted beat is taken in the cycle it is presented, except that dispatch and writeback beats that coincide with recovery are dropped.

Top module: `ffr_tracker`

## Requirements
- R1: After reset every future entry reads valid with value 0 and producer tag 0, and `disp_tag` is 0.
- R2: An accepted dispatch clears the valid flag of its destination entry and stores `disp_tag` there as the producer. `disp_tag` then advances by one, wrapping modulo 2^TW.
- R3: A writeback whose tag equals the stored producer of a not-valid entry writes its data into that entry and sets the entry valid on the next clock edge.
- R4: A writeback to an entry that is already valid, or whose tag differs from the stored producer, leaves that entry's flag and value unchanged.
- R5: When a dispatch and a writeback name the same register in one cycle, the dispatch wins. The entry ends not valid and holds the new tag.
- R6: Retirement writes `ret_data` into the architectural file and does not change any future entry.
- R7: A cycle with `recover` high makes every future entry valid, with the architectural value that includes any retirement in that same cycle.
- R8: Dispatch and writeback beats presented together with `recover` are ignored, and `disp_tag` does not advance.
- R9: Each read port independently returns the flag, value and producer tag of the entry selected by its own index field. Port p uses bits [p*AW +: AW] of `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recover | input | 1 | Restore future file from architectural file |
| disp_valid | input | 1 | Dispatch beat present |
| disp_dst | input | AW | Dispatch destination register |
| disp_tag | output | TW | Producer tag given to this cycle's dispatch |
| wb_valid | input | 1 | Writeback beat present |
| wb_dst | input | AW | Writeback register |
| wb_tag | input | TW | Tag of the finishing producer |
| wb_data | input | DW | Result value |
| ret_valid | input | 1 | Retirement beat present |
| ret_dst | input | AW | Retiring register |
| ret_data | input | DW | Retiring value |
| rd_idx | input | NRP*AW | Read register indices, one field per port |
| rd_valid | output | NRP | Entry valid per port |
| rd_data | output | NRP*DW | Entry value per port |
| rd_tag | output | NRP*TW | Stored producer tag per port |

## Verification
Several functions can fall in one cycle. A dispatch can coincide with a writeback to the same register, and a retirement can coincide with a recovery pulse. The stimulus table places both pairs in single rows. In the first case the entry must end not valid, holding the new tag, with the old matching result discarded. In the second case the restored entry must show the value retired in that very cycle. A dispatch also rides along with the recovery row, and the bench judges the outcome from the read ports and from the next tag handed out.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  localparam int FFR_NREG = 8;
  localparam int FFR_DW   = 32;
  localparam int FFR_TW   = 4;
  localparam int FFR_NRP  = 2;
endpackage

// File: rtl/ffr_tag_gen.sv
module ffr_tag_gen #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [TW-1:0] tag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   tag_q <= '0;
    else if (adv) tag_q <= tag_q + TW'(1);
  end
endmodule

// File: rtl/ffr_arch_file.sv
module ffr_arch_file #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ret_en,
  input  logic [AW-1:0]             ret_dst,
  input  logic [DW-1:0]             ret_data,
  output logic [NREG-1:0][DW-1:0]   arch_nx
);
  logic [NREG-1:0][DW-1:0] arch_q;

  // next-state view: includes this cycle's retirement, used by recovery
  always_comb begin
    arch_nx = arch_q;
    if (ret_en) arch_nx[ret_dst] = ret_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) arch_q <= '0;
    else        arch_q <= arch_nx;
  end
endmodule

// File: rtl/ffr_future_file.sv
module ffr_future_file #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int TW   = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recover,
  input  logic [NREG-1:0][DW-1:0] arch_nx,
  input  logic                    disp_en,
  input  logic [AW-1:0]           disp_dst,
  input  logic [TW-1:0]           disp_tag,
  input  logic                    wb_en,
  input  logic [AW-1:0]           wb_dst,
  input  logic [TW-1:0]           wb_tag,
  input  logic [DW-1:0]           wb_data,
  output logic [NREG-1:0]         fv,
  output logic [NREG-1:0][TW-1:0] ftag,
  output logic [NREG-1:0][DW-1:0] fdata
);
  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic hit_d, hit_w;
    assign hit_d = disp_en && (disp_dst == AW'(i));
    assign hit_w = wb_en && (wb_dst == AW'(i)) && !fv[i] && (ftag[i] == wb_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fv[i]    <= 1'b1;
        ftag[i]  <= '0;
        fdata[i] <= '0;
      end else if (recover) begin
        fv[i]    <= 1'b1;
        fdata[i] <= arch_nx[i];
      end else if (hit_d) begin
        fv[i]    <= 1'b0;
        ftag[i]  <= disp_tag;
      end else if (hit_w) begin
        fv[i]    <= 1'b1;
        fdata[i] <= wb_data;
      end
    end
  end
endmodule

// File: rtl/ffr_tracker.sv
module ffr_tracker #(
  parameter int NREG = ffr_pkg::FFR_NREG,
  parameter int DW   = ffr_pkg::FFR_DW,
  parameter int TW   = ffr_pkg::FFR_TW,
  parameter int NRP  = ffr_pkg::FFR_NRP,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recover,
  input  logic              disp_valid,
  input  logic [AW-1:0]     disp_dst,
  output logic [TW-1:0]     disp_tag,
  input  logic              wb_valid,
  input  logic [AW-1:0]     wb_dst,
  input  logic [TW-1:0]     wb_tag,
  input  logic [DW-1:0]     wb_data,
  input  logic              ret_valid,
  input  logic [AW-1:0]     ret_dst,
  input  logic [DW-1:0]     ret_data,
  input  logic [NRP*AW-1:0] rd_idx,
  output logic [NRP-1:0]    rd_valid,
  output logic [NRP*DW-1:0] rd_data,
  output logic [NRP*TW-1:0] rd_tag
);
  logic                    disp_en, wb_en;
  logic [NREG-1:0][DW-1:0] arch_nx;
  logic [NREG-1:0]         fv;
  logic [NREG-1:0][TW-1:0] ftag;
  logic [NREG-1:0][DW-1:0] fdata;

  assign disp_en = disp_valid && !recover;
  assign wb_en   = wb_valid && !recover;

  ffr_tag_gen #(.TW(TW)) tag_i (
    .clk(clk), .rst_n(rst_n), .adv(disp_en), .tag_q(disp_tag)
  );

  ffr_arch_file #(.NREG(NREG), .DW(DW)) arch_i (
    .clk(clk), .rst_n(rst_n), .ret_en(ret_valid), .ret_dst(ret_dst),
    .ret_data(ret_data), .arch_nx(arch_nx)
  );

  ffr_future_file #(.NREG(NREG), .DW(DW), .TW(TW)) fut_i (
    .clk(clk), .rst_n(rst_n), .recover(recover), .arch_nx(arch_nx),
    .disp_en(disp_en), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .wb_en(wb_en), .wb_dst(wb_dst), .wb_tag(wb_tag), .wb_data(wb_data),
    .fv(fv), .ftag(ftag), .fdata(fdata)
  );

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    logic [AW-1:0] sel;
    assign sel                   = rd_idx[p*AW +: AW];
    assign rd_valid[p]           = fv[sel];
    assign rd_data[p*DW +: DW]   = fdata[sel];
    assign rd_tag[p*TW +: TW]    = ftag[sel];
  end
endmodule

// File: rtl/ffr_tracker_chk.sv
module ffr_tracker_chk #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int TW   = 4,
  parameter int AW   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    recover,
  input logic                    disp_valid,
  input logic [AW-1:0]           disp_dst,
  input logic [TW-1:0]           disp_tag,
  input logic                    wb_valid,
  input logic [AW-1:0]           wb_dst,
  input logic [TW-1:0]           wb_tag,
  input logic                    ret_valid,
  input logic [NREG-1:0]         fv,
  input logic [NREG-1:0][TW-1:0] ftag,
  input logic [NREG-1:0][DW-1:0] fdata
);
  assert_tag_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !recover |=> disp_tag == $past(disp_tag) + TW'(1));

  assert_dispatch_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !recover |=> !fv[$past(disp_dst)] && ftag[$past(disp_dst)] == $past(disp_tag));

  assert_match_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !recover && !fv[wb_dst] && ftag[wb_dst] == wb_tag &&
    !(disp_valid && disp_dst == wb_dst) |=> fv[$past(wb_dst)]);

  assert_valid_entry_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !recover && fv[wb_dst] && !(disp_valid && disp_dst == wb_dst)
    |=> fv[$past(wb_dst)] && fdata[$past(wb_dst)] == $past(fdata[wb_dst]));

  assert_retire_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !disp_valid && !wb_valid && !recover |=> $stable(fv) && $stable(fdata));

  assert_recover_all_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> &fv);

  assert_recover_holds_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> $stable(disp_tag));
endmodule

bind ffr_tracker ffr_tracker_chk #(.NREG(NREG), .DW(DW), .TW(TW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .recover(recover), .disp_valid(disp_valid),
  .disp_dst(disp_dst), .disp_tag(disp_tag), .wb_valid(wb_valid), .wb_dst(wb_dst),
  .wb_tag(wb_tag), .ret_valid(ret_valid), .fv(fv), .ftag(ftag), .fdata(fdata)
);

// File: tb/ffr_tracker_tb.sv
module ffr_tracker_tb_top;
  localparam int NREG = 8, DW = 32, TW = 4, NRP = 2, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, recover = 1'b0;
  logic disp_valid = 1'b0, wb_valid = 1'b0, ret_valid = 1'b0;
  logic [AW-1:0] disp_dst = '0, wb_dst = '0, ret_dst = '0;
  logic [TW-1:0] disp_tag, wb_tag = '0;
  logic [DW-1:0] wb_data = '0, ret_data = '0;
  logic [NRP*AW-1:0] rd_idx = '0;
  logic [NRP-1:0]    rd_valid;
  logic [NRP*DW-1:0] rd_data;
  logic [NRP*TW-1:0] rd_tag;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ffr_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .recover(recover), .disp_valid(disp_valid),
    .disp_dst(disp_dst), .disp_tag(disp_tag), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .wb_tag(wb_tag), .wb_data(wb_data), .ret_valid(ret_valid), .ret_dst(ret_dst),
    .ret_data(ret_data), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_tag(rd_tag)
  );

  typedef struct packed {
    logic          dv;   logic [2:0] dd;
    logic          wv;   logic [2:0] wd;  logic [3:0] wt; logic [31:0] wdat;
    logic          rv;   logic [2:0] rdst; logic [31:0] rdat;
    logic          rec;
    logic [2:0]    chk;  logic ev; logic [31:0] eval;  // eval: data if valid else tag
    logic [3:0]    req;
  } row_t;

  localparam int NROW = 15;
  localparam row_t TBL [NROW] = '{
    '{1'b1,3'd3, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b0,32'd0,        4'd2}, // R2 tag0
    '{1'b1,3'd5, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd5,1'b0,32'd1,        4'd2}, // R2 tag1
    '{1'b0,3'd0, 1'b1,3'd3,4'd0,32'hAAAA0003, 1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b1,32'hAAAA0003, 4'd3}, // R3
    '{1'b1,3'd3, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b0,32'd2,        4'd2}, // R2 tag2
    '{1'b0,3'd0, 1'b1,3'd3,4'd0,32'hDEAD,     1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b0,32'd2,        4'd4}, // R4 stale tag
    '{1'b1,3'd3, 1'b1,3'd3,4'd2,32'h33,       1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b0,32'd3,        4'd5}, // R5 collision
    '{1'b1,3'd6, 1'b1,3'd5,4'd1,32'h55,       1'b0,3'd0,32'h0,    1'b0, 3'd5,1'b1,32'h55,       4'd3}, // R3 other reg
    '{1'b0,3'd0, 1'b1,3'd5,4'd1,32'h99,       1'b0,3'd0,32'h0,    1'b0, 3'd5,1'b1,32'h55,       4'd4}, // R4 already valid
    '{1'b0,3'd0, 1'b0,3'd0,4'd0,32'h0,        1'b1,3'd3,32'h1234, 1'b0, 3'd3,1'b0,32'd3,        4'd6}, // R6
    '{1'b0,3'd0, 1'b1,3'd3,4'd3,32'h77,       1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b1,32'h77,       4'd3}, // R3
    '{1'b1,3'd2, 1'b1,3'd6,4'd4,32'hBAD,      1'b1,3'd5,32'h5555, 1'b1, 3'd5,1'b1,32'h5555,     4'd7}, // R7 retire bypass
    '{1'b0,3'd0, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd3,1'b1,32'h1234,     4'd7}, // R7 restored
    '{1'b0,3'd0, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd2,1'b1,32'h0,        4'd8}, // R8 dispatch dropped
    '{1'b1,3'd6, 1'b0,3'd0,4'd0,32'h0,        1'b0,3'd0,32'h0,    1'b0, 3'd6,1'b0,32'd5,        4'd8}, // R8 tag not advanced
    '{1'b0,3'd0, 1'b1,3'd6,4'd5,32'hCAFE,     1'b0,3'd0,32'h0,    1'b0, 3'd6,1'b1,32'hCAFE,     4'd3}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 1'b0; wb_valid = 1'b0; ret_valid = 1'b0; recover = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state through both ports, R9 independent ports
    for (int r = 0; r < NREG; r++) begin
      rd_idx = {AW'(NREG - 1 - r), AW'(r)};
      #1;
      chk("R1 valid p0", 32'(rd_valid[0]), 32'd1);
      chk("R1 data p0", rd_data[0 +: DW], 32'd0);
      chk("R9 valid p1", 32'(rd_valid[1]), 32'd1);
      chk("R1 tag p1", 32'(rd_tag[TW +: TW]), 32'd0);
    end
    chk("R1 disp_tag", 32'(disp_tag), 32'd0);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      disp_valid = TBL[i].dv; disp_dst = TBL[i].dd;
      wb_valid = TBL[i].wv; wb_dst = TBL[i].wd; wb_tag = TBL[i].wt; wb_data = TBL[i].wdat;
      ret_valid = TBL[i].rv; ret_dst = TBL[i].rdst; ret_data = TBL[i].rdat;
      recover = TBL[i].rec;
      rd_idx[0 +: AW] = TBL[i].chk;
      @(posedge clk); #1;
      idle();
      chk($sformatf("R%0d row%0d valid", TBL[i].req, i), 32'(rd_valid[0]), 32'(TBL[i].ev));
      if (TBL[i].ev) chk($sformatf("R%0d row%0d data", TBL[i].req, i), rd_data[0 +: DW], TBL[i].eval);
      else           chk($sformatf("R%0d row%0d tag", TBL[i].req, i), 32'(rd_tag[0 +: TW]), TBL[i].eval);
    end

    // R9: two ports on different registers in the same cycle
    @(negedge clk);
    rd_idx = {AW'(6), AW'(3)};
    #1;
    chk("R9 p0 data", rd_data[0 +: DW], 32'h1234);
    chk("R9 p1 data", rd_data[DW +: DW], 32'hCAFE);
    chk("R9 p1 valid", 32'(rd_valid[1]), 32'd1);

    // R2 wrap: counter is 6, ten dispatches bring it to 0
    chk("R2 tag before wrap", 32'(disp_tag), 32'd6);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      disp_valid = 1'b1; disp_dst = 3'd0;
      @(posedge clk); #1;
      idle();
    end
    chk("R2 tag wrapped", 32'(disp_tag), 32'd0);
    rd_idx[0 +: AW] = 3'd0;
    #1;
    chk("R2 last tag stored", 32'(rd_tag[0 +: TW]), 32'd15);

    // R4: writeback with an older tag to the waiting entry is dropped
    @(negedge clk);
    wb_valid = 1'b1; wb_dst = 3'd0; wb_tag = 4'd14; wb_data = 32'hFFFF;
    @(posedge clk); #1;
    idle();
    chk("R4 old tag ignored", 32'(rd_valid[0]), 32'd0);

    @(negedge clk);
    finish_run();
  end
endmodule